// File: doc/BRIEF.md
# Serial converter output shifter with tag pass-through

This block is the digital output stage of a serial analog-to-digital converter that generates its own bit clock. A conversion starts when an active-low strobe and an active-low chip select are both low. At that moment the block captures the result of the previous conversion and the level of a tag input. Its busy output then goes low, and the conversion itself is modelled as a fixed number of system clock cycles.

While busy is low, the block divides the system clock to make sixteen bit-clock pulses and shifts the captured word out, most significant bit first. Each bit is set up while the bit clock is low and is held unchanged while it is high, so a receiver can sample on either edge.

Once the last bit has gone out, the data line carries the captured tag level and the bit clock stays low. Because of this, the data line of one converter can feed the tag input of the next, and a chain of converters can be read as one long word. When the conversion ends, the block samples the core's result word and keeps it for the next conversion.

Top module: `adc_shift_out`

## Requirements
- R1: After reset, busy_n is 1, dclk is 0, sdata is 0 and stale_word is 0.
- R2: A conversion starts only on a clock edge at which strobe_n and cs_n are both low and at least one of them was high at the previous edge. The two may go low in either order. One of them low on its own starts nothing, and holding both low after a conversion does not start another.
- R3: busy_n is low for exactly CONV_CYCLES clock cycles per conversion, starting the cycle after the start edge.
- R4: Exactly DATA_W rising edges of dclk occur during each conversion. Each half period of dclk lasts CLK_DIV clock cycles.
- R5: The word shifted out during a conversion is the value result_in had when the previous conversion ended. It is sent most significant bit first, one bit per dclk pulse.
- R6: The first conversion after reset shifts out all zeros and drives stale_word to 1. Every later conversion drives stale_word to 0. The flag holds until the next start.
- R7: From the last falling edge of dclk until the next start, sdata equals tag_in as sampled at the start edge. Later changes of tag_in have no effect on it.
- R8: dclk is 0 whenever busy_n is 1.
- R9: sdata changes only while dclk is low. It is stable across every cycle in which dclk is high.
- R10: A new start condition (a fresh falling edge of the combined select) while busy_n is low is ignored: the conversion length and the pulse count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low conversion strobe |
| cs_n | input | 1 | Active-low chip select |
| result_in | input | DATA_W | Result word from the converter core, sampled when a conversion ends |
| tag_in | input | 1 | Level passed to sdata after the last bit |
| busy_n | output | 1 | Low while a conversion is in progress |
| dclk | output | 1 | Generated bit clock |
| sdata | output | 1 | Serial data, MSB first, then the tag level |
| stale_word | output | 1 | High while the word being shifted is the undefined first word |

## Verification
The bench goes after three groups of corner cases.

First, the start condition. It lowers the selects in both orders and holds one low on its own. It also keeps both low across the end of a conversion. A design with a level-sensitive start would fire again at once, and one that trusted a single select would start early.

Second, it gives a fresh start condition in the middle of a conversion. A design that restarted would lengthen busy or emit extra pulses.

Third, it flips tag_in right after the start. It checks the first conversion's zero word and flag, and it compares the bit sent on every rising dclk edge with the level seen just before that edge. A design that sampled the tag late, shifted on the rising edge, or dropped the tail bit would show a wrong tag, a torn bit or a word shifted by one place.

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 80,
  parameter int CLK_DIV     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              cs_n,
  input  logic [DATA_W-1:0] result_in,
  input  logic              tag_in,
  output logic              busy_n,
  output logic              dclk,
  output logic              sdata,
  output logic              stale_word
);
  localparam int HALVES = 2 * DATA_W;
  localparam int CW     = $clog2(CONV_CYCLES + 1);
  localparam int DW     = $clog2(CLK_DIV + 1);
  localparam int HW     = $clog2(HALVES + 1);

  logic              start_q;
  logic              tag_q;
  logic              have_word;
  logic [CW-1:0]     conv_cnt;
  logic [DW-1:0]     div_cnt;
  logic [HW-1:0]     half_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] last_word;

  wire start_req = ~(strobe_n | cs_n);
  wire fire      = start_req & ~start_q & busy_n;
  wire conv_last = conv_cnt == CW'(CONV_CYCLES - 1);
  wire tick      = div_cnt == DW'(CLK_DIV - 1);
  wire more      = half_cnt != HW'(HALVES);
  wire last_half = half_cnt == HW'(HALVES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      busy_n     <= 1'b1;
      dclk       <= 1'b0;
      sdata      <= 1'b0;
      stale_word <= 1'b0;
      tag_q      <= 1'b0;
      have_word  <= 1'b0;
      conv_cnt   <= '0;
      div_cnt    <= '0;
      half_cnt   <= '0;
      shreg      <= '0;
      last_word  <= '0;
    end else begin
      start_q <= start_req;
      if (fire) begin
        busy_n     <= 1'b0;
        conv_cnt   <= '0;
        div_cnt    <= '0;
        half_cnt   <= '0;
        dclk       <= 1'b0;
        shreg      <= last_word;
        sdata      <= last_word[DATA_W-1];
        tag_q      <= tag_in;
        stale_word <= ~have_word;
      end else if (!busy_n) begin
        conv_cnt <= conv_cnt + 1'b1;
        if (conv_last) begin
          busy_n    <= 1'b1;
          last_word <= result_in;
          have_word <= 1'b1;
        end
        if (more) begin
          if (tick) begin
            div_cnt  <= '0;
            half_cnt <= half_cnt + 1'b1;
            dclk     <= ~dclk;
            if (dclk) begin
              shreg <= shreg << 1;
              sdata <= last_half ? tag_q : shreg[DATA_W-2];
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_shift_out_chk.sv
module adc_shift_out_chk #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 80,
  parameter int CLK_DIV     = 2
) (
  input logic clk,
  input logic rst_n,
  input logic strobe_n,
  input logic cs_n,
  input logic busy_n,
  input logic dclk,
  input logic sdata
);
  int   lo_cnt;
  int   rise_cnt;
  logic dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt   <= 0;
      rise_cnt <= 0;
      dclk_q   <= 1'b0;
    end else begin
      dclk_q <= dclk;
      lo_cnt <= busy_n ? 0 : lo_cnt + 1;
      if (busy_n)               rise_cnt <= 0;
      else if (dclk && !dclk_q) rise_cnt <= rise_cnt + 1;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!strobe_n && !cs_n));
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> lo_cnt == CONV_CYCLES);
  p_pulses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> rise_cnt == DATA_W);
  p_idle_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && $past(busy_n)) |-> $stable(sdata));
  p_idle_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !dclk);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk && $past(dclk)) |-> $stable(sdata));
endmodule

bind adc_shift_out adc_shift_out_chk #(
  .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .CLK_DIV(CLK_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .cs_n(cs_n),
  .busy_n(busy_n), .dclk(dclk), .sdata(sdata)
);

// File: tb/adc_shift_out_tb.sv
module adc_shift_out_tb;
  localparam int DATA_W = 16;
  localparam int CONV   = 80;
  localparam int DIV    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1;
  logic cs_n = 1'b1;
  logic [DATA_W-1:0] result_in = '0;
  logic tag_in = 1'b0;
  logic busy_n, dclk, sdata, stale_word;

  always #5 clk = ~clk;

  adc_shift_out #(.DATA_W(DATA_W), .CONV_CYCLES(CONV), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .cs_n(cs_n),
    .result_in(result_in), .tag_in(tag_in),
    .busy_n(busy_n), .dclk(dclk), .sdata(sdata), .stale_word(stale_word)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DATA_W+1:0] exp_q[$];
  logic [DATA_W-1:0] prev_word = '0;
  bit have = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: collects bits on dclk rises, compares at the end of each conversion
  logic p_busy = 1'b1, p_dclk = 1'b0, p_sdata = 1'b0;
  logic [DATA_W-1:0] bits;
  int nbits, lowcnt;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_busy && !busy_n) begin
        bits = '0; nbits = 0; lowcnt = 1;
      end else if (!busy_n) begin
        lowcnt++;
      end
      if (!busy_n && dclk && !p_dclk) begin
        bits = {bits[DATA_W-2:0], sdata};
        nbits++;
        check(sdata == p_sdata, "R9", "bit changed across rising dclk", sdata, p_sdata);
      end
      if (!p_busy && busy_n) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "conversion with no expected entry", 0, 1);
        end else begin
          logic [DATA_W+1:0] e;
          e = exp_q.pop_front();
          check(bits == e[DATA_W-1:0], "R5", "shifted word", bits, e[DATA_W-1:0]);
          check(nbits == DATA_W, "R4", "dclk pulse count", nbits, DATA_W);
          check(lowcnt == CONV, "R3", "busy_n low cycles", lowcnt, CONV);
          check(sdata == e[DATA_W], "R7", "tag after LSB", sdata, e[DATA_W]);
          check(dclk == 1'b0, "R8", "dclk after conversion", dclk, 0);
          check(stale_word == e[DATA_W+1], "R6", "stale_word flag", stale_word, e[DATA_W+1]);
        end
      end
      p_busy = busy_n; p_dclk = dclk; p_sdata = sdata;
    end
  end

  task automatic conv(input bit cs_first, input bit tg, input logic [DATA_W-1:0] nxt,
                      input bit hold_low, input bit poke);
    @(negedge clk);
    result_in = nxt;
    tag_in = tg;
    if (cs_first) cs_n = 1'b0; else strobe_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_n == 1'b1, "R2", "started with one select low", busy_n, 1);
    exp_q.push_back({~have, tg, (have ? prev_word : {DATA_W{1'b0}})});
    if (cs_first) strobe_n = 1'b0; else cs_n = 1'b0;
    @(negedge clk);
    check(busy_n == 1'b0, "R2", "busy_n after both selects low", busy_n, 0);
    tag_in = ~tg;
    if (!hold_low) begin
      repeat (2) @(negedge clk);
      strobe_n = 1'b1; cs_n = 1'b1;
    end
    if (poke) begin
      // R10: fresh start condition in mid-conversion
      repeat (10) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      strobe_n = 1'b0;
      repeat (2) @(negedge clk);
      strobe_n = 1'b1; cs_n = 1'b1;
    end
    while (!busy_n) @(negedge clk);
    prev_word = nxt;
    have = 1'b1;
    if (hold_low) begin
      bit stayed;
      stayed = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!busy_n) stayed = 1'b0;
      end
      check(stayed, "R2", "retrigger while selects held low", !stayed, 0);
      strobe_n = 1'b1; cs_n = 1'b1;
    end
    repeat (4) @(negedge clk);
    check(dclk == 1'b0, "R8", "dclk idle", dclk, 0);
    check(sdata == tg, "R7", "idle data holds start tag", sdata, tg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_n == 1'b1, "R1", "reset busy_n", busy_n, 1);
    check(dclk == 1'b0, "R1", "reset dclk", dclk, 0);
    check(sdata == 1'b0, "R1", "reset sdata", sdata, 0);
    check(stale_word == 1'b0, "R1", "reset stale_word", stale_word, 0);

    strobe_n = 1'b0;
    repeat (10) @(negedge clk);
    check(busy_n == 1'b1, "R2", "strobe_n alone", busy_n, 1);
    strobe_n = 1'b1; cs_n = 1'b0;
    repeat (10) @(negedge clk);
    check(busy_n == 1'b1, "R2", "cs_n alone", busy_n, 1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);

    conv(1'b0, 1'b1, 16'hA5C3, 1'b0, 1'b0);  // R6 first word zero
    conv(1'b1, 1'b0, 16'h8001, 1'b0, 1'b0);
    conv(1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b1);  // R10
    conv(1'b1, 1'b1, 16'h0000, 1'b1, 1'b0);  // R2 hold low
    conv(1'b0, 1'b0, 16'h1234, 1'b0, 1'b0);
    conv(1'b0, 1'b1, 16'h7FFE, 1'b0, 1'b0);
    conv(1'b1, 1'b0, 16'h5555, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3", "conversions left unfinished", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule